// File: doc/BRIEF.md
# Multi-Register Floating-Point Transfer Sequencer

This block takes the decoded fields of a floating-point load-multiple or store-multiple instruction and turns them into a stream of 32-bit word transfers. Each register moves as three consecutive words. For every word the block presents the byte address, the register number and the word position inside that register. The memory side accepts each word with a valid/ready handshake. When the last word has been accepted, the block reports the new base value and whether that value is to be written back to the base register.

All fields are captured in the clock edge at which the block accepts the instruction, and it accepts one only while idle. The block then spends one setup cycle forming the adjusted base and the first address, and then steps through the words. The offset is an unsigned count of words. It is scaled to bytes and then added or subtracted according to the direction bit. Address arithmetic wraps modulo 2^32. Register numbers wrap modulo the register-file size.

Top module: `lsm_xfer_seq`

## Requirements
- R1: The register count field `cnt_i` (bit 1 = instruction bit 22, bit 0 = instruction bit 15) selects 1, 2 or 3 registers for the values 01, 10 and 11, and 4 registers for 00. The block issues exactly three words per register before it signals done.
- R2: Register numbers start at `freg_i` and ascend modulo 8, so start 6 with four registers gives 6, 7, 0, 1. `word_idx_o` runs 0, 1, 2 within each register.
- R3: The adjusted base is `base_i + 4*offset_i` when `up_i`=1 and `base_i - 4*offset_i` when `up_i`=0, both modulo 2^32.
- R4: The first word address is the adjusted base when `pre_i`=1 and the unmodified `base_i` when `pre_i`=0.
- R5: Each later word address is 4 above the previous word address, modulo 2^32.
- R6: `done_o` is high for exactly one cycle, the cycle after the last word handshake. In that cycle `wb_val_o` holds the adjusted base and `wb_en_o` equals the captured writeback bit, in both pre- and post-indexed modes. `wb_en_o` is low in all other cycles.
- R7: An instruction is accepted on a rising edge where `idle_o`=1 and `start_i`=1. This is followed by one setup cycle with `word_valid_o`=0. With `word_ready_i` held at 1, `idle_o` stays low for exactly 1+3N cycles for N registers.
- R8: While `word_valid_o`=1 and `word_ready_i`=0, the word address, register and word index hold their values. They advance only on a handshake.
- R9: `start_i` and every field input are ignored while `idle_o`=0. The sequence in progress keeps the fields captured at acceptance.
- R10: `idle_o` is high in the cycle in which `done_o` is high, so a new instruction can be accepted in that same cycle.
- R11: While `rst_n`=0, `idle_o`=1, `word_valid_o`=0, `done_o`=0 and `wb_en_o`=0. A sequence in progress is abandoned.
- R12: `word_load_o` equals the captured load/store bit (1 = load) for every word of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Instruction offered this cycle |
| pre_i | input | 1 | 1 = index before first transfer, 0 = after |
| up_i | input | 1 | 1 = add offset, 0 = subtract |
| cnt_i | input | CNT_W (2) | Register count field, 00 means four |
| wb_i | input | 1 | Write adjusted base back |
| load_i | input | 1 | 1 = load from memory, 0 = store |
| offset_i | input | OFF_W (8) | Unsigned offset in words |
| freg_i | input | log2(NUM_FREGS) (3) | First register number |
| base_i | input | ADDR_W (32) | Base register value |
| idle_o | output | 1 | Ready to accept an instruction |
| word_valid_o | output | 1 | A word transfer is presented |
| word_ready_i | input | 1 | Memory side accepts the word |
| word_addr_o | output | ADDR_W (32) | Byte address of the word |
| word_reg_o | output | log2(NUM_FREGS) (3) | Register the word belongs to |
| word_idx_o | output | 2 | Word position in the register (0..2) |
| word_load_o | output | 1 | Direction of the sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Write back `wb_val_o` (only with done) |
| wb_val_o | output | ADDR_W (32) | Adjusted base value |

## Verification
Completion of one instruction and acceptance of the next can fall in the same cycle. The cycle in which `done_o` reports the writeback value is also an idle cycle in which `start_i` is sampled. The vector walk offers every instruction in the done cycle of the one before it, so instructions run back to back. The bench checks that the done pulse still carries the earlier instruction's writeback value and enable, and that the next setup cycle shows done low with the new first address following. A separate directed case leaves an idle gap between instructions, and a third holds `start_i` high with different fields throughout a busy sequence to show that acceptance happens only when idle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   typedef enum logic [1:0] {
      LSM_IDLE  = 2'd0,
      LSM_SETUP = 2'd1,
      LSM_XFER  = 2'd2
   } lsm_state_e;

endpackage

// File: rtl/lsm_seq_ctrl.sv
module lsm_seq_ctrl
   import lsm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic ready_i,
   input  logic last_i,
   output logic idle_o,
   output logic capture_o,
   output logic setup_o,
   output logic valid_o,
   output logic adv_o,
   output logic done_o
);

   lsm_state_e state_q;
   logic       done_q;

   assign idle_o    = (state_q == LSM_IDLE);
   assign capture_o = idle_o && start_i;
   assign setup_o   = (state_q == LSM_SETUP);
   assign valid_o   = (state_q == LSM_XFER);
   assign adv_o     = valid_o && ready_i;
   assign done_o    = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LSM_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            LSM_IDLE: begin
               if (start_i) state_q <= LSM_SETUP;
            end
            LSM_SETUP: begin
               state_q <= LSM_XFER;
            end
            LSM_XFER: begin
               if (ready_i && last_i) begin
                  state_q <= LSM_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= LSM_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lsm_base_calc.sv
module lsm_base_calc #(
   parameter int ADDR_W       = 32,
   parameter int OFF_W        = 8,
   parameter int STEP_SHIFT   = 2,
   parameter bit SINGLE_ADDER = 1'b1
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic              up_i,
   input  logic              pre_i,
   output logic [ADDR_W-1:0] mod_base_o,
   output logic [ADDR_W-1:0] first_addr_o
);

   logic [ADDR_W-1:0] off_bytes;

   assign off_bytes = ADDR_W'(off_i) << STEP_SHIFT;

   generate
      if (SINGLE_ADDER) begin : g_one_adder
         logic [ADDR_W-1:0] signed_off;
         assign signed_off = up_i ? off_bytes : (~off_bytes + ADDR_W'(1));
         assign mod_base_o = base_i + signed_off;
      end else begin : g_two_adders
         logic [ADDR_W-1:0] sum_v;
         logic [ADDR_W-1:0] dif_v;
         assign sum_v      = base_i + off_bytes;
         assign dif_v      = base_i - off_bytes;
         assign mod_base_o = up_i ? sum_v : dif_v;
      end
   endgenerate

   assign first_addr_o = pre_i ? mod_base_o : base_i;

endmodule

// File: rtl/lsm_word_walk.sv
module lsm_word_walk #(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 3,
   parameter int IDX_W  = 2,
   parameter int WPR    = 3,
   parameter int RCNT_W = 3,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic [ADDR_W-1:0] first_addr_i,
   input  logic [REG_W-1:0]  first_reg_i,
   input  logic [RCNT_W-1:0] nregs_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [REG_W-1:0]  reg_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              last_o
);

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WPR - 1);

   logic [ADDR_W-1:0] addr_q;
   logic [REG_W-1:0]  reg_q;
   logic [RCNT_W-1:0] rleft_q;
   logic [IDX_W-1:0]  idx_q;
   logic              reg_end;

   generate
      if (WPR > 1) begin : g_idx_cnt
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               idx_q <= '0;
            end else if (load_i) begin
               idx_q <= '0;
            end else if (adv_i) begin
               idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
            end
         end
         assign reg_end = (idx_q == IDX_LAST);
      end else begin : g_idx_none
         assign idx_q   = '0;
         assign reg_end = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         reg_q   <= '0;
         rleft_q <= '0;
      end else if (load_i) begin
         addr_q  <= first_addr_i;
         reg_q   <= first_reg_i;
         rleft_q <= nregs_i;
      end else if (adv_i) begin
         addr_q <= addr_q + ADDR_W'(STEP);
         if (reg_end) begin
            reg_q   <= reg_q + REG_W'(1);
            rleft_q <= rleft_q - RCNT_W'(1);
         end
      end
   end

   assign addr_o = addr_q;
   assign reg_o  = reg_q;
   assign idx_o  = idx_q;
   assign last_o = reg_end && (rleft_q == RCNT_W'(1));

endmodule

// File: rtl/lsm_xfer_seq.sv
module lsm_xfer_seq #(
   parameter int ADDR_W        = 32,
   parameter int OFF_W         = 8,
   parameter int NUM_FREGS     = 8,
   parameter int WORDS_PER_REG = 3,
   parameter int WORD_BYTES    = 4,
   parameter int CNT_W         = 2,
   parameter bit SINGLE_ADDER  = 1'b1,
   localparam int REG_W        = $clog2(NUM_FREGS),
   localparam int IDX_W        = (WORDS_PER_REG > 1) ? $clog2(WORDS_PER_REG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              pre_i,
   input  logic              up_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              wb_i,
   input  logic              load_i,
   input  logic [OFF_W-1:0]  offset_i,
   input  logic [REG_W-1:0]  freg_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              idle_o,
   output logic              word_valid_o,
   input  logic              word_ready_i,
   output logic [ADDR_W-1:0] word_addr_o,
   output logic [REG_W-1:0]  word_reg_o,
   output logic [IDX_W-1:0]  word_idx_o,
   output logic              word_load_o,
   output logic              done_o,
   output logic              wb_en_o,
   output logic [ADDR_W-1:0] wb_val_o
);

   localparam int STEP_SHIFT = $clog2(WORD_BYTES);
   localparam int MAX_REGS   = 2 ** CNT_W;
   localparam int RCNT_W     = $clog2(MAX_REGS + 1);

   generate
      if ((NUM_FREGS & (NUM_FREGS - 1)) != 0 || NUM_FREGS < 2) begin : g_bad_fregs
         $error("NUM_FREGS must be a power of two of at least 2");
      end
      if ((WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_bytes
         $error("WORD_BYTES must be a power of two");
      end
      if (WORDS_PER_REG < 1) begin : g_bad_wpr
         $error("WORDS_PER_REG must be at least 1");
      end
      if (ADDR_W < OFF_W + STEP_SHIFT + 1) begin : g_bad_addr
         $error("ADDR_W too narrow for the scaled offset");
      end
   endgenerate

   logic              capture;
   logic              setup;
   logic              adv;
   logic              last_word;

   logic              pre_q;
   logic              up_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              wb_q;
   logic              load_q;
   logic [OFF_W-1:0]  off_q;
   logic [REG_W-1:0]  freg_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] wb_val_q;

   logic [ADDR_W-1:0] mod_base;
   logic [ADDR_W-1:0] first_addr;
   logic [RCNT_W-1:0] nregs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q  <= 1'b0;
         up_q   <= 1'b0;
         cnt_q  <= '0;
         wb_q   <= 1'b0;
         load_q <= 1'b0;
         off_q  <= '0;
         freg_q <= '0;
         base_q <= '0;
      end else if (capture) begin
         pre_q  <= pre_i;
         up_q   <= up_i;
         cnt_q  <= cnt_i;
         wb_q   <= wb_i;
         load_q <= load_i;
         off_q  <= offset_i;
         freg_q <= freg_i;
         base_q <= base_i;
      end
   end

   assign nregs = (cnt_q == '0) ? RCNT_W'(MAX_REGS) : RCNT_W'(cnt_q);

   lsm_seq_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .ready_i   (word_ready_i),
      .last_i    (last_word),
      .idle_o    (idle_o),
      .capture_o (capture),
      .setup_o   (setup),
      .valid_o   (word_valid_o),
      .adv_o     (adv),
      .done_o    (done_o)
   );

   lsm_base_calc #(
      .ADDR_W       (ADDR_W),
      .OFF_W        (OFF_W),
      .STEP_SHIFT   (STEP_SHIFT),
      .SINGLE_ADDER (SINGLE_ADDER)
   ) u_base (
      .base_i       (base_q),
      .off_i        (off_q),
      .up_i         (up_q),
      .pre_i        (pre_q),
      .mod_base_o   (mod_base),
      .first_addr_o (first_addr)
   );

   lsm_word_walk #(
      .ADDR_W (ADDR_W),
      .REG_W  (REG_W),
      .IDX_W  (IDX_W),
      .WPR    (WORDS_PER_REG),
      .RCNT_W (RCNT_W),
      .STEP   (WORD_BYTES)
   ) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (setup),
      .adv_i        (adv),
      .first_addr_i (first_addr),
      .first_reg_i  (freg_q),
      .nregs_i      (nregs),
      .addr_o       (word_addr_o),
      .reg_o        (word_reg_o),
      .idx_o        (word_idx_o),
      .last_o       (last_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_val_q <= '0;
      end else if (setup) begin
         wb_val_q <= mod_base;
      end
   end

   assign wb_val_o    = wb_val_q;
   assign wb_en_o     = done_o && wb_q;
   assign word_load_o = load_q;

endmodule

// File: rtl/lsm_xfer_seq_chk.sv
module lsm_xfer_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 3,
   parameter int IDX_W  = 2,
   parameter int WPR    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              idle_o,
   input logic              word_valid_o,
   input logic              word_ready_i,
   input logic [ADDR_W-1:0] word_addr_o,
   input logic [REG_W-1:0]  word_reg_o,
   input logic [IDX_W-1:0]  word_idx_o,
   input logic              done_o
);

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WPR - 1);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && !word_ready_i) |=>
         (word_valid_o && $stable(word_addr_o) && $stable(word_reg_o) && $stable(word_idx_o)));

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && word_ready_i) |=>
         (!word_valid_o || word_addr_o == $past(word_addr_o) + ADDR_W'(4)));

   // R2
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && word_ready_i && word_idx_o != IDX_LAST) |=>
         (word_valid_o && word_reg_o == $past(word_reg_o) && word_idx_o == $past(word_idx_o) + 1'b1));

   // R2
   reg_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && word_ready_i && word_idx_o == IDX_LAST) |=>
         (!word_valid_o || (word_reg_o == REG_W'($past(word_reg_o) + 1'b1) && word_idx_o == '0)));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> idle_o);

   // R7
   valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> !idle_o);

endmodule

bind lsm_xfer_seq lsm_xfer_seq_chk #(
   .ADDR_W (ADDR_W),
   .REG_W  (REG_W),
   .IDX_W  (IDX_W),
   .WPR    (WORDS_PER_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .idle_o       (idle_o),
   .word_valid_o (word_valid_o),
   .word_ready_i (word_ready_i),
   .word_addr_o  (word_addr_o),
   .word_reg_o   (word_reg_o),
   .word_idx_o   (word_idx_o),
   .done_o       (done_o)
);

// File: tb/tb_lsm_xfer_seq.sv
`timescale 1ns/1ps
module tb_lsm_xfer_seq;

   typedef struct packed {
      logic        pre;
      logic        up;
      logic [1:0]  cnt;
      logic        wb;
      logic        ld;
      logic [7:0]  off;
      logic [2:0]  fr;
      logic [31:0] base;
      logic [2:0]  exp_regs;
      logic [31:0] exp_wb;
      logic [1:0]  mode;     // 0 plain, 1 stalls, 2 start held while busy
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 8'h04, 3'd0, 32'h0000_1000, 3'd1, 32'h0000_1010, 2'd0},
      '{1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 8'h10, 3'd3, 32'h0000_2000, 3'd2, 32'h0000_2040, 2'd1},
      '{1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 8'h08, 3'd5, 32'h0000_3000, 3'd3, 32'h0000_2FE0, 2'd0},
      '{1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 8'h00, 3'd6, 32'h0000_4000, 3'd4, 32'h0000_4000, 2'd2},
      '{1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 8'hFF, 3'd2, 32'h0000_0100, 3'd4, 32'hFFFF_FD04, 2'd0},
      '{1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 8'hFF, 3'd7, 32'hFFFF_FFF0, 3'd1, 32'h0000_03EC, 2'd0},
      '{1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h01, 3'd7, 32'hFFFF_FFF8, 3'd3, 32'hFFFF_FFFC, 2'd1},
      '{1'b1, 1'b0, 2'b10, 1'b1, 1'b1, 8'h02, 3'd0, 32'h0000_0008, 3'd2, 32'h0000_0000, 2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        pre_i = 1'b0;
   logic        up_i = 1'b0;
   logic [1:0]  cnt_i = '0;
   logic        wb_i = 1'b0;
   logic        load_i = 1'b0;
   logic [7:0]  offset_i = '0;
   logic [2:0]  freg_i = '0;
   logic [31:0] base_i = '0;
   logic        word_ready_i = 1'b0;
   logic        idle_o;
   logic        word_valid_o;
   logic [31:0] word_addr_o;
   logic [2:0]  word_reg_o;
   logic [1:0]  word_idx_o;
   logic        word_load_o;
   logic        done_o;
   logic        wb_en_o;
   logic [31:0] wb_val_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   lsm_xfer_seq dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .pre_i        (pre_i),
      .up_i         (up_i),
      .cnt_i        (cnt_i),
      .wb_i         (wb_i),
      .load_i       (load_i),
      .offset_i     (offset_i),
      .freg_i       (freg_i),
      .base_i       (base_i),
      .idle_o       (idle_o),
      .word_valid_o (word_valid_o),
      .word_ready_i (word_ready_i),
      .word_addr_o  (word_addr_o),
      .word_reg_o   (word_reg_o),
      .word_idx_o   (word_idx_o),
      .word_load_o  (word_load_o),
      .done_o       (done_o),
      .wb_en_o      (wb_en_o),
      .wb_val_o     (wb_val_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive_fields(input vec_t v);
      pre_i = v.pre; up_i = v.up; cnt_i = v.cnt; wb_i = v.wb;
      load_i = v.ld; offset_i = v.off; freg_i = v.fr; base_i = v.base;
   endtask

   // Entered at a negedge with the block idle; returns at the done negedge.
   task automatic run_vec(input vec_t v);
      int nw;
      int busy;
      logic [31:0] first;
      nw    = 3 * int'(v.exp_regs);
      busy  = 0;
      first = v.pre ? v.exp_wb : v.base;
      chk(idle_o == 1'b1, "R10", "idle when offered", 32'(idle_o), 32'd1);
      drive_fields(v);
      start_i = 1'b1;
      word_ready_i = 1'b0;
      @(negedge clk);
      busy++;
      if (v.mode == 2'd2) begin
         pre_i = ~v.pre; up_i = ~v.up; cnt_i = v.cnt + 2'd1; wb_i = ~v.wb;
         load_i = ~v.ld; offset_i = ~v.off; freg_i = v.fr + 3'd3; base_i = ~v.base;
      end else begin
         start_i = 1'b0;
      end
      chk(word_valid_o == 1'b0 && idle_o == 1'b0, "R7", "setup cycle", 32'(word_valid_o), 32'd0);
      chk(done_o == 1'b0, "R6", "done low after pulse", 32'(done_o), 32'd0);
      for (int w = 0; w < nw; w++) begin
         logic [31:0] ea;
         logic [2:0]  er;
         ea = first + 32'(4 * w);
         er = v.fr + 3'(w / 3);
         @(negedge clk);
         busy++;
         chk(word_valid_o == 1'b1, "R1", "word valid", 32'(word_valid_o), 32'd1);
         chk(word_addr_o == ea, (w == 0) ? "R4" : "R5", "word address", word_addr_o, ea);
         chk(word_reg_o == er && word_idx_o == 2'(w % 3), "R2", "reg/idx",
             {word_reg_o, 2'b00, word_idx_o}, {er, 2'b00, 2'(w % 3)});
         chk(word_load_o == v.ld, (v.mode == 2'd2) ? "R9" : "R12", "direction",
             32'(word_load_o), 32'(v.ld));
         if (v.mode == 2'd1 && (w % 2) == 0) begin
            word_ready_i = 1'b0;
            @(negedge clk);
            busy++;
            chk(word_valid_o && word_addr_o == ea && word_reg_o == er, "R8", "hold on stall",
                word_addr_o, ea);
         end
         word_ready_i = 1'b1;
         if (w == nw - 1) start_i = 1'b0;
      end
      @(negedge clk);
      word_ready_i = 1'b0;
      chk(done_o == 1'b1 && idle_o == 1'b1, "R6", "done pulse", {30'd0, done_o, idle_o}, 32'd3);
      chk(wb_val_o == v.exp_wb, "R3", "writeback value", wb_val_o, v.exp_wb);
      chk(wb_en_o == v.wb, "R6", "writeback enable", 32'(wb_en_o), 32'(v.wb));
      if (v.mode == 2'd0)
         chk(busy == 1 + nw, "R7", "busy cycles", 32'(busy), 32'(1 + nw));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      vec_t g;
      // Reset state
      repeat (3) @(negedge clk);
      chk(idle_o && !word_valid_o && !done_o && !wb_en_o, "R11", "reset state",
          {28'd0, idle_o, word_valid_o, done_o, wb_en_o}, 32'h8);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector walk, each instruction offered in the done cycle of the previous
      for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

      // Idle gap, then another instruction
      @(negedge clk);
      chk(done_o == 1'b0 && wb_en_o == 1'b0, "R6", "wb_en low when idle", 32'(wb_en_o), 32'd0);
      run_vec(VECS[2]);

      // Reset in the middle of a four-register sequence
      @(negedge clk);
      g = VECS[3];
      g.mode = 2'd0;
      drive_fields(g);
      start_i = 1'b1;
      word_ready_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(idle_o && !word_valid_o && !done_o && !wb_en_o, "R11", "abandon on reset",
          {28'd0, idle_o, word_valid_o, done_o, wb_en_o}, 32'h8);
      rst_n = 1'b1;
      word_ready_i = 1'b0;
      @(negedge clk);
      run_vec(VECS[6]);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule